// File: doc/BRIEF.md
# Parity-Guarded Write Queue with Poison Forwarding

This block is a first-in first-out store for 32-bit write data in which every word carries one parity bit. At enqueue the parity bit is either computed on the spot from the data (for a source whose data is known to be good) or taken unchanged from the sender's bus. Because generated parity is always good, a mismatch on a word from the trusted source points at damage inside the store. A mismatch on a bus word may come from the bus or from the store.

The word at the head of the queue is checked on its way out. A failing word raises no interrupt and no fatal signal. It is handed downstream with a poison tag beside the data, and a sticky status flag records that a poisoned word left the queue. Software clears that flag with a write-one strobe.

On the write side, a wait-state indicator blocks capture. On such a cycle neither data nor parity is taken, so a parity fault present only during a wait state can never reach the queue. Full and empty flags give back-pressure to the writer and to the reader.

Top module: `parity_wq`

## Requirements
- R1: After reset `empty`=1, `full`=0, `err_flag`=0 and `rd_poison`=0.
- R2: Words leave in the order they were captured. `rd_data` always shows the oldest stored word while `empty`=0, and a pop (`rd_en`=1 with `empty`=0) advances to the next word on the following clock.
- R3: `full` is 1 exactly when DEPTH words are held. A write attempted while `full`=1 is dropped, even if a pop happens in the same cycle.
- R4: A read attempted while `empty`=1 has no effect. A write and a read in the same cycle on an empty queue store the word and pop nothing.
- R5: With `par_src`=0 the stored parity bit is generated as the XOR of the 32 data bits, so `wr_par` is ignored and such a word is never poisoned at the output.
- R6: With `par_src`=1 the stored parity bit is `wr_par` exactly as received. The head word shows `rd_poison`=1 when the XOR of its 32 data bits and its stored parity bit is 1 (even parity violated), and 0 otherwise.
- R7: A capture happens only when `wr_en`=1, `wr_wait`=0 and `full`=0. While `wr_wait`=1 nothing is stored, whatever the data and parity inputs carry.
- R8: Popping a word with `rd_poison`=1 sets `err_flag` from the next clock on. The flag then stays set until it is cleared. No other output reacts to the error.
- R9: `err_clr`=1 clears `err_flag` on the next clock. If a poisoned pop occurs in the same cycle, setting takes priority and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_src | input | 1 | 0: generate parity at enqueue, 1: store the received parity |
| wr_en | input | 1 | Write request |
| wr_wait | input | 1 | Wait-state cycle; no capture when 1 |
| wr_data | input | 32 | Write data word |
| wr_par | input | 1 | Received parity bit (used when `par_src`=1) |
| rd_en | input | 1 | Read (pop) request |
| err_clr | input | 1 | Write-one-to-clear strobe for `err_flag` |
| rd_data | output | 32 | Data of the oldest word |
| rd_poison | output | 1 | Poison tag of the oldest word |
| full | output | 1 | Queue holds DEPTH words |
| empty | output | 1 | Queue holds no word |
| err_flag | output | 1 | Sticky parity-error status |

## Verification
The assertions assume that inputs change only away from the rising edge and carry known values once reset is released. They also assume that, with the reader idle, nothing but a push or a clear alters the visible head. The bench drives all inputs at the falling edge from its main process and keeps them at 0 or 1, never X. It mixes free random patterns with directed phases that fill past DEPTH, read past empty, hold wait states with corrupt parity, and collide a poisoned pop with a clear strobe. These phases stay within what the assertions take for granted.

// File: rtl/parity_wq.sv
module parity_wq #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_src,
  input  logic              wr_en,
  input  logic              wr_wait,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_par,
  input  logic              rd_en,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_poison,
  output logic              full,
  output logic              empty,
  output logic              err_flag
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DATA_W:0] mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [CW-1:0]   cnt;
  logic [DATA_W:0] head;
  logic            push, pop, par_bit;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push    = wr_en & ~wr_wait & ~full;
  assign pop     = rd_en & ~empty;
  assign par_bit = par_src ? wr_par : ^wr_data;

  assign head      = mem[rd_ptr];
  assign rd_data   = head[DATA_W-1:0];
  assign rd_poison = ~empty & (^head);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {par_bit, wr_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt      <= '0;
      err_flag <= 1'b0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (pop && rd_poison) err_flag <= 1'b1;
      else if (err_clr)     err_flag <= 1'b0;
    end
  end
endmodule

module parity_wq_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_wait,
  input logic              rd_en,
  input logic              err_clr,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_poison,
  input logic              full,
  input logic              empty,
  input logic              err_flag
);
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R3
  AST_POISON_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_poison |-> !empty); // R6
  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !rd_en) |=> (!empty && $stable(rd_data) && $stable(rd_poison))); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_en) |=> full); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && (!wr_en || wr_wait)) |=> empty); // R4
  AST_WAIT_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && wr_wait) |=> empty); // R7
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_poison) |=> err_flag); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag); // R8
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !(rd_en && rd_poison)) |=> !err_flag); // R9
endmodule

bind parity_wq parity_wq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_wait(wr_wait),
  .rd_en(rd_en), .err_clr(err_clr), .rd_data(rd_data),
  .rd_poison(rd_poison), .full(full), .empty(empty), .err_flag(err_flag)
);

// File: tb/parity_wq_test.sv
module parity_wq_test;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 8;
  localparam int LIMIT  = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic par_src = 1'b0, wr_en = 1'b0, wr_wait = 1'b0, wr_par = 1'b0;
  logic rd_en = 1'b0, err_clr = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic rd_poison, full, empty, err_flag;

  parity_wq #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .par_src(par_src), .wr_en(wr_en),
    .wr_wait(wr_wait), .wr_data(wr_data), .wr_par(wr_par), .rd_en(rd_en),
    .err_clr(err_clr), .rd_data(rd_data), .rd_poison(rd_poison),
    .full(full), .empty(empty), .err_flag(err_flag)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;
  string tag = "R1";

  logic [DATA_W:0] q [$];
  logic m_err = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DATA_W:0] act, input logic [DATA_W:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit e_empty = (q.size() == 0);
    check(empty == e_empty, tag, "empty", 33'(empty), 33'(e_empty));
    check(full == (q.size() == DEPTH), tag, "full", 33'(full), 33'(q.size() == DEPTH));
    check(err_flag == m_err, tag, "err_flag", 33'(err_flag), 33'(m_err));
    if (!e_empty) begin
      check(rd_data == q[0][DATA_W-1:0], tag, "rd_data", 33'(rd_data), 33'(q[0][DATA_W-1:0]));
      check(rd_poison == q[0][DATA_W], tag, "rd_poison", 33'(rd_poison), 33'(q[0][DATA_W]));
    end else
      check(rd_poison == 1'b0, tag, "rd_poison", 33'(rd_poison), 33'(0));
  endtask

  // one clock: inputs applied now, model advanced after the edge, outputs compared at next negedge
  task automatic step(input bit src, input bit we, input bit wt, input logic [DATA_W-1:0] d,
                      input bit p, input bit re, input bit clr);
    bit push, pop, bad, head_bad;
    par_src = src; wr_en = we; wr_wait = wt; wr_data = d; wr_par = p; rd_en = re; err_clr = clr;
    push = we && !wt && (q.size() < DEPTH);
    pop  = re && (q.size() > 0);
    bad  = src ? ((^d) ^ p) : 1'b0;
    head_bad = pop ? q[0][DATA_W] : 1'b0;
    @(posedge clk);
    if (pop) void'(q.pop_front());
    if (push) q.push_back({bad, d});
    if (head_bad) m_err = 1'b1;
    else if (clr) m_err = 1'b0;
    @(negedge clk);
    compare();
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, LIMIT);
      report();
    end
  end

  initial begin
    logic [DATA_W-1:0] w;
    repeat (2) @(negedge clk);
    tag = "R1"; compare();
    rst_n = 1'b1;
    @(negedge clk); compare();

    // R5: generated parity, wrong wr_par must not poison
    tag = "R5";
    for (int i = 0; i < 6; i++) begin
      w = $urandom; step(0, 1, 0, w, ~(^w), 0, 0);
    end
    // R2: order and show-ahead while draining
    tag = "R2";
    for (int i = 0; i < 6; i++) step(0, 0, 0, '0, 0, 1, 0);

    // R3: overfill, then push during pop when full
    tag = "R3";
    for (int i = 0; i < DEPTH + 3; i++) step(0, 1, 0, 32'hA500_0000 + i, 0, 0, 0);
    step(0, 1, 0, 32'hDEAD_BEEF, 0, 1, 0);
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, '0, 0, 1, 0);

    // R4: read on empty, push+pop on empty
    tag = "R4";
    step(0, 0, 0, '0, 0, 1, 0);
    step(0, 1, 0, 32'h1234_5678, 0, 1, 0);
    step(0, 0, 0, '0, 0, 1, 0);

    // R6: received parity, good and bad
    tag = "R6";
    w = 32'h0000_0003; step(1, 1, 0, w, 1'b0, 0, 0);
    w = 32'h0000_0007; step(1, 1, 0, w, 1'b0, 0, 0);
    w = 32'h0000_0007; step(1, 1, 0, w, 1'b1, 0, 0);
    w = 32'hFFFF_FFFE; step(1, 1, 0, w, 1'b0, 0, 0);

    // R8: pop the poisoned word, flag set and sticky
    tag = "R8";
    for (int i = 0; i < 4; i++) step(1, 0, 0, '0, 0, 1, 0);
    step(1, 0, 0, '0, 0, 0, 0);

    // R9: clear, then clear colliding with poisoned pop
    tag = "R9";
    step(1, 0, 0, '0, 0, 0, 1);
    step(1, 1, 0, 32'h0000_0001, 1'b0, 0, 0);
    step(1, 0, 0, '0, 0, 0, 1);
    step(1, 0, 0, '0, 0, 1, 1);
    step(1, 0, 0, '0, 0, 0, 1);

    // R7: wait states with corrupt parity are never captured
    tag = "R7";
    for (int i = 0; i < 5; i++) begin
      w = $urandom; step(1, 1, 1, w, ~(^w), 0, 0);
    end
    w = 32'h0F0F_0F0F; step(1, 1, 0, w, ^w, 0, 0);
    step(1, 1, 1, 32'hFFFF_0001, 1'b0, 1, 0);
    step(1, 0, 0, '0, 0, 1, 0);

    // mixed random traffic across all rules
    tag = "R2";
    for (int i = 0; i < 2000; i++) begin
      w = $urandom;
      step($urandom_range(0, 1) == 1, $urandom_range(0, 2) != 0, $urandom_range(0, 3) == 0,
           w, ($urandom_range(0, 4) == 0) ? ~(^w) : ^w,
           $urandom_range(0, 2) != 0, $urandom_range(0, 9) == 0);
    end

    finished = 1;
    report();
  end
endmodule